// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block keeps the one reservation that a hart may hold between a load-reserved (LR) and a later store-conditional (SC), and it decides whether each SC may write memory. An LR records the granule that holds its address. An SC anywhere inside that granule succeeds if nothing has broken the reservation in between. A write from any other agent, seen on a snoop port, breaks it. A store by this hart breaks it only when a parameter asks for that. Every SC consumes the reservation, whether it passes or fails.

The datapath is 64 bits wide. The memory model outside the block supplies read data for an LR in the same cycle as the request. The block returns the LR result one cycle later, and it sign-extends a word-sized result to 64 bits. An SC that passes drives a registered write strobe, with address, data and size, toward memory. An LR or SC whose address is not aligned to its own size raises a trap flag and changes nothing else.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset no reservation is held and all outputs are low. An SC issued with no earlier LR reports failure and does not write.
- R2: Only one reservation exists. A later LR replaces the earlier one, so an SC to the first LR's granule fails and an SC to the second LR's granule passes. LR and SC are never requested in the same cycle.
- R3: A reservation covers the naturally aligned granule of GRANULE_BYTES bytes that holds the LR address. An SC at any aligned address inside that granule passes. An SC just below or just above it fails.
- R4: Every aligned SC clears the reservation, pass or fail. A second SC with no LR in between fails, whether it targets the same address, another address in the same granule, or another granule.
- R5: A snoop write into the reserved granule clears the reservation. This includes a snoop in the same cycle as the SC, which makes that SC fail. A snoop to another granule has no effect. A snoop in the same cycle as an LR is ordered before the LR, so the new reservation survives.
- R6: With LOCAL_CLEARS = 0, a local store into the reserved granule leaves the reservation intact. With LOCAL_CLEARS = 1, it clears the reservation.
- R7: One cycle after an aligned LR, lrDone is high and lrResult carries the data. For a word LR (lrDouble = 0), the word is taken from memRdata[31:0] and sign-extended from bit 31. For a doubleword LR, all 64 bits of memRdata are returned unchanged.
- R8: A word access needs address bits [1:0] = 0 and a doubleword access needs bits [2:0] = 0. A misaligned LR or SC raises lrMisaligned or scMisaligned one cycle later. It raises neither lrDone nor scDone, performs no write, and neither sets nor clears the reservation.
- R9: One cycle after an aligned SC, scDone is high and scFail is 0 for success or 1 for failure. memWe is high exactly when the SC succeeded. It comes with memWaddr equal to the SC address and memWdouble equal to the SC size. memWdata carries the SC data for a doubleword, or {32'b0, scData[31:0]} for a word.
- R10: The reservation does not expire. After 16 or more cycles with no interfering write, including local stores elsewhere, an SC to the reserved granule still passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lrValid | input | 1 | LR request |
| lrDouble | input | 1 | LR size: 1 for doubleword, 0 for word |
| lrAddr | input | ADDR_W | LR byte address |
| memRdata | input | 64 | Memory data at lrAddr, presented in the LR cycle |
| scValid | input | 1 | SC request |
| scDouble | input | 1 | SC size: 1 for doubleword, 0 for word |
| scAddr | input | ADDR_W | SC byte address |
| scData | input | 64 | SC store data |
| localStValid | input | 1 | Ordinary store by this hart |
| localStAddr | input | ADDR_W | Address of the local store |
| snoopValid | input | 1 | Write by another agent |
| snoopAddr | input | ADDR_W | Address of the snooped write |
| lrDone | output | 1 | LR result valid |
| lrResult | output | 64 | LR result |
| scDone | output | 1 | SC outcome valid |
| scFail | output | 1 | SC result code: 0 for success, 1 for failure |
| memWe | output | 1 | Memory write strobe for a successful SC |
| memWaddr | output | ADDR_W | Write address |
| memWdata | output | 64 | Write data |
| memWdouble | output | 1 | Write size |
| lrMisaligned | output | 1 | LR misaligned trap |
| scMisaligned | output | 1 | SC misaligned trap |

## Verification
Every result of this block passes through one register stage. lrDone, lrResult, scDone, scFail, the memory write fields and both trap flags therefore belong to the request presented one clock earlier, and the reservation update takes effect at that same edge. The bench drives each request on a falling edge and samples all outputs on the next falling edge, which is one rising edge later. It also applies any observed memory write to its own memory model at that point, so the next LR cannot race it. A reference model of the reservation is advanced in the same step, so each request's expected pass or fail depends only on the requests that came before it.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  localparam int XLEN = 64;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic setRes;
    logic clrRes;
    logic lrLoad;
    logic scReport;
    logic scWrite;
    logic lrTrap;
    logic scTrap;
  } lrscStrobe_t;
endpackage

// File: rtl/lrsc_ctrl.sv
module lrsc_ctrl
  import lrsc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter bit LOCAL_CLEARS = 1'b0
) (
  input  logic              lrValid,
  input  logic              lrDouble,
  input  logic [ADDR_W-1:0] lrAddr,
  input  logic              scValid,
  input  logic              scDouble,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic              scHit,
  input  logic              snoopHit,
  input  logic              localHit,
  output lrscStrobe_t       strobe
);
  logic lrMis, scMis, lrOk, scOk, scPass, killRes;

  always_comb begin
    lrMis   = lrValid && (lrDouble ? (lrAddr[2:0] != 3'd0) : (lrAddr[1:0] != 2'd0));
    scMis   = scValid && (scDouble ? (scAddr[2:0] != 3'd0) : (scAddr[1:0] != 2'd0));
    lrOk    = lrValid && !lrMis;
    scOk    = scValid && !scMis && !lrValid;
    killRes = snoopHit || (LOCAL_CLEARS && localHit);
    // a foreign write in the SC's own cycle wins over the SC
    scPass  = scOk && scHit && !snoopHit;

    strobe          = '0;
    strobe.setRes   = lrOk;
    strobe.clrRes   = scOk || killRes;
    strobe.lrLoad   = lrOk;
    strobe.scReport = scOk;
    strobe.scWrite  = scPass;
    strobe.lrTrap   = lrMis;
    strobe.scTrap   = scMis;
  end
endmodule

// File: rtl/lrsc_datapath.sv
module lrsc_datapath
  import lrsc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int GRANULE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  lrscStrobe_t       strobe,
  input  logic              lrDouble,
  input  logic [ADDR_W-1:0] lrAddr,
  input  logic [XLEN-1:0]   memRdata,
  input  logic              scDouble,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic [XLEN-1:0]   scData,
  input  logic              localStValid,
  input  logic [ADDR_W-1:0] localStAddr,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              scHit,
  output logic              snoopHit,
  output logic              localHit,
  output logic              lrDone,
  output logic [XLEN-1:0]   lrResult,
  output logic              scDone,
  output logic              scFail,
  output logic              memWe,
  output logic [ADDR_W-1:0] memWaddr,
  output logic [XLEN-1:0]   memWdata,
  output logic              memWdouble,
  output logic              lrMisaligned,
  output logic              scMisaligned
);
  localparam int GRAN_LSB = $clog2(GRANULE_BYTES);
  localparam int TAG_W    = ADDR_W - GRAN_LSB;

  logic             resValid;
  logic [TAG_W-1:0] resTag;
  logic [XLEN-1:0]  lrValue;
  logic [XLEN-1:0]  wrValue;

  // one tag comparator per address source
  logic [ADDR_W-1:0] probeAddr [3];
  logic [2:0]        probeHit;
  assign probeAddr[0] = scAddr;
  assign probeAddr[1] = snoopAddr;
  assign probeAddr[2] = localStAddr;

  for (genvar i = 0; i < 3; i++) begin : g_probe
    assign probeHit[i] = resValid && (probeAddr[i][ADDR_W-1:GRAN_LSB] == resTag);
  end

  assign scHit    = probeHit[0];
  assign snoopHit = snoopValid && probeHit[1];
  assign localHit = localStValid && probeHit[2];

  assign lrValue = lrDouble ? memRdata : {{32{memRdata[31]}}, memRdata[31:0]};
  assign wrValue = scDouble ? scData : {32'd0, scData[31:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resTag   <= '0;
    end else if (strobe.setRes) begin
      resValid <= 1'b1;
      resTag   <= lrAddr[ADDR_W-1:GRAN_LSB];
    end else if (strobe.clrRes) begin
      resValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lrDone       <= 1'b0;
      lrResult     <= '0;
      scDone       <= 1'b0;
      scFail       <= 1'b0;
      memWe        <= 1'b0;
      memWaddr     <= '0;
      memWdata     <= '0;
      memWdouble   <= 1'b0;
      lrMisaligned <= 1'b0;
      scMisaligned <= 1'b0;
    end else begin
      lrDone       <= strobe.lrLoad;
      lrResult     <= strobe.lrLoad ? lrValue : '0;
      scDone       <= strobe.scReport;
      scFail       <= strobe.scReport && !strobe.scWrite;
      memWe        <= strobe.scWrite;
      memWaddr     <= strobe.scWrite ? scAddr : '0;
      memWdata     <= strobe.scWrite ? wrValue : '0;
      memWdouble   <= strobe.scWrite && scDouble;
      lrMisaligned <= strobe.lrTrap;
      scMisaligned <= strobe.scTrap;
    end
  end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int GRANULE_BYTES = 16,
  parameter bit LOCAL_CLEARS = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lrValid,
  input  logic              lrDouble,
  input  logic [ADDR_W-1:0] lrAddr,
  input  logic [63:0]       memRdata,
  input  logic              scValid,
  input  logic              scDouble,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic [63:0]       scData,
  input  logic              localStValid,
  input  logic [ADDR_W-1:0] localStAddr,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              lrDone,
  output logic [63:0]       lrResult,
  output logic              scDone,
  output logic              scFail,
  output logic              memWe,
  output logic [ADDR_W-1:0] memWaddr,
  output logic [63:0]       memWdata,
  output logic              memWdouble,
  output logic              lrMisaligned,
  output logic              scMisaligned
);
  lrscStrobe_t strobe;
  logic        scHit, snoopHit, localHit;

  lrsc_ctrl #(.ADDR_W(ADDR_W), .LOCAL_CLEARS(LOCAL_CLEARS)) uCtrl (
    .lrValid(lrValid), .lrDouble(lrDouble), .lrAddr(lrAddr),
    .scValid(scValid), .scDouble(scDouble), .scAddr(scAddr),
    .scHit(scHit), .snoopHit(snoopHit), .localHit(localHit),
    .strobe(strobe)
  );

  lrsc_datapath #(.ADDR_W(ADDR_W), .GRANULE_BYTES(GRANULE_BYTES)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lrDouble(lrDouble), .lrAddr(lrAddr), .memRdata(memRdata),
    .scDouble(scDouble), .scAddr(scAddr), .scData(scData),
    .localStValid(localStValid), .localStAddr(localStAddr),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .scHit(scHit), .snoopHit(snoopHit), .localHit(localHit),
    .lrDone(lrDone), .lrResult(lrResult), .scDone(scDone), .scFail(scFail),
    .memWe(memWe), .memWaddr(memWaddr), .memWdata(memWdata),
    .memWdouble(memWdouble), .lrMisaligned(lrMisaligned),
    .scMisaligned(scMisaligned)
  );
endmodule

// File: rtl/lrsc_chk.sv
module lrsc_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              lrValid,
  input logic              scValid,
  input logic              lrDone,
  input logic              scDone,
  input logic              scFail,
  input logic              memWe,
  input logic [ADDR_W-1:0] memWaddr,
  input logic              memWdouble,
  input logic              lrMisaligned,
  input logic              scMisaligned
);
  // R2
  req_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(lrValid && scValid));

  // R9
  we_on_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (scDone && !scFail));

  // R9
  sc_done_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    scDone |-> $past(scValid));

  // R7
  lr_done_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    lrDone |-> $past(lrValid));

  // R4
  second_sc_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (scDone && $past(scDone)) |-> scFail);

  // R8
  sc_trap_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    scMisaligned |-> (!scDone && !memWe));

  // R8
  lr_trap_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    lrMisaligned |-> !lrDone);

  // R8
  wr_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memWdouble ? (memWaddr[2:0] == 3'd0) : (memWaddr[1:0] == 2'd0)));
endmodule

bind lrsc_monitor lrsc_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .lrValid(lrValid), .scValid(scValid),
  .lrDone(lrDone), .scDone(scDone), .scFail(scFail), .memWe(memWe),
  .memWaddr(memWaddr), .memWdouble(memWdouble),
  .lrMisaligned(lrMisaligned), .scMisaligned(scMisaligned)
);

// File: tb/sim_lrsc_monitor.sv
`timescale 1ns/1ps
module sim_lrsc_monitor;
  localparam int AW = 16;
  localparam int GB = 16;
  localparam int GL = $clog2(GB);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lrValid = 0, lrDouble = 0, scValid = 0, scDouble = 0;
  logic localStValid = 0, snoopValid = 0;
  logic [AW-1:0] lrAddr = '0, scAddr = '0, localStAddr = '0, snoopAddr = '0;
  logic [63:0] scData = '0, memRdata;
  logic lrDone, scDone, scFail, memWe, memWdouble, lrMisaligned, scMisaligned;
  logic [63:0] lrResult, memWdata;
  logic [AW-1:0] memWaddr;

  logic [63:0] mem [256];
  int total = 0, bad = 0;
  bit refValid = 0;
  logic [AW-GL-1:0] refTag = '0;

  always #2 clk = ~clk;

  always_comb begin
    if (lrDouble) memRdata = mem[lrAddr[10:3]];
    else memRdata = {32'd0, lrAddr[2] ? mem[lrAddr[10:3]][63:32] : mem[lrAddr[10:3]][31:0]};
  end

  lrsc_monitor #(.ADDR_W(AW), .GRANULE_BYTES(GB), .LOCAL_CLEARS(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .lrValid(lrValid), .lrDouble(lrDouble), .lrAddr(lrAddr),
    .memRdata(memRdata), .scValid(scValid), .scDouble(scDouble), .scAddr(scAddr),
    .scData(scData), .localStValid(localStValid), .localStAddr(localStAddr),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr), .lrDone(lrDone),
    .lrResult(lrResult), .scDone(scDone), .scFail(scFail), .memWe(memWe),
    .memWaddr(memWaddr), .memWdata(memWdata), .memWdouble(memWdouble),
    .lrMisaligned(lrMisaligned), .scMisaligned(scMisaligned));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit misal(input logic [AW-1:0] a, input bit dbl);
    return dbl ? (a[2:0] != 0) : (a[1:0] != 0);
  endfunction

  // one request cycle; outputs sampled one rising edge later
  task automatic issue(input bit lr, input bit sc, input logic [AW-1:0] a, input bit dbl,
                       input logic [63:0] d, input bit sn, input logic [AW-1:0] snA,
                       input bit loc, input logic [AW-1:0] locA, input string req);
    bit mis, snHit, pass;
    logic [63:0] expLr, expWd, raw;
    @(negedge clk);
    lrValid = lr; scValid = sc; lrAddr = a; scAddr = a; lrDouble = dbl; scDouble = dbl;
    scData = d; snoopValid = sn; snoopAddr = snA; localStValid = loc; localStAddr = locA;
    mis   = (lr || sc) && misal(a, dbl);
    snHit = sn && refValid && (snA[AW-1:GL] == refTag);
    pass  = sc && !mis && refValid && (a[AW-1:GL] == refTag) && !snHit;
    raw   = dbl ? mem[a[10:3]] : {32'd0, a[2] ? mem[a[10:3]][63:32] : mem[a[10:3]][31:0]};
    expLr = dbl ? raw : {{32{raw[31]}}, raw[31:0]};
    expWd = dbl ? d : {32'd0, d[31:0]};
    if (lr && !mis) begin refValid = 1; refTag = a[AW-1:GL]; end
    else if ((sc && !mis) || snHit) refValid = 0;
    @(negedge clk);
    lrValid = 0; scValid = 0; snoopValid = 0; localStValid = 0;
    check({req, " lrDone"}, 64'(lrDone), 64'(lr && !mis));
    if (lr && !mis) check({req, " lrResult"}, lrResult, expLr);
    check({req, " scDone"}, 64'(scDone), 64'(sc && !mis));
    if (sc && !mis) check({req, " scFail"}, 64'(scFail), 64'(!pass));
    check({req, " memWe"}, 64'(memWe), 64'(pass));
    if (pass) begin
      check({req, " memWaddr"}, 64'(memWaddr), 64'(a));
      check({req, " memWdata"}, memWdata, expWd);
      check({req, " memWdouble"}, 64'(memWdouble), 64'(dbl));
    end
    check({req, " lrMisaligned"}, 64'(lrMisaligned), 64'(lr && mis));
    check({req, " scMisaligned"}, 64'(scMisaligned), 64'(sc && mis));
    if (memWe) begin
      if (memWdouble) mem[memWaddr[10:3]] = memWdata;
      else if (memWaddr[2]) mem[memWaddr[10:3]][63:32] = memWdata[31:0];
      else mem[memWaddr[10:3]][31:0] = memWdata[31:0];
    end
  endtask

  task automatic lr_(input logic [AW-1:0] a, input bit dbl, input string req);
    issue(1, 0, a, dbl, 0, 0, 0, 0, 0, req);
  endtask
  task automatic sc_(input logic [AW-1:0] a, input bit dbl, input logic [63:0] d, input string req);
    issue(0, 1, a, dbl, d, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {32'(i * 32'h9e3779b9), 32'(i * 32'h85ebca6b)};
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 lrDone", 64'(lrDone), 0);
    check("R1 scDone", 64'(scDone), 0);
    check("R1 memWe", 64'(memWe), 0);
    check("R1 lrResult", lrResult, 0);
    rstN = 1;
    sc_(16'h0100, 0, 64'h11, "R1 sc without lr");

    // R7 word sign extension and doubleword passthrough
    mem[8'h30] = 64'h7fff_0001_8000_0002;
    lr_(16'h0180, 0, "R7 word low negative");
    lr_(16'h0184, 0, "R7 word high positive");
    lr_(16'h0180, 1, "R7 doubleword");
    for (int i = 0; i < 16; i++) begin
      mem[8'h40 + i] = {32'h1 << (i * 2), 32'h1 << (i * 2 + 1)};
      lr_(16'h0200 + 16'(i * 8), 0, "R7 sweep low");
      lr_(16'h0204 + 16'(i * 8), 0, "R7 sweep high");
    end

    // R3 granule boundary sweep, word and doubleword SC
    for (int off = -16; off < 32; off += 4) begin
      lr_(16'h0300, 0, "R3 lr");
      sc_(16'(32'h0300 + off), 0, 64'(32'hA5000000 + off), "R3 word sc");
    end
    for (int off = -16; off < 32; off += 8) begin
      lr_(16'h0308, 1, "R3 lr dbl");
      sc_(16'(32'h0300 + off), 1, 64'hC0DE_0000_0000_0000 + 64'(off), "R3 dbl sc");
    end
    lr_(16'h0300, 0, "R9 readback");

    // R2 replacement
    lr_(16'h0400, 0, "R2 lr a"); lr_(16'h0440, 0, "R2 lr b");
    sc_(16'h0400, 0, 1, "R2 sc old set");
    lr_(16'h0400, 0, "R2 lr a"); lr_(16'h0440, 0, "R2 lr b");
    sc_(16'h0444, 0, 2, "R2 sc new set");

    // R4 second SC fails: same address, same set, other set
    lr_(16'h0500, 1, "R4 lr"); sc_(16'h0500, 1, 3, "R4 first sc");
    sc_(16'h0500, 1, 4, "R4 same addr");
    lr_(16'h0500, 1, "R4 lr"); sc_(16'h0500, 1, 5, "R4 first sc");
    sc_(16'h0508, 1, 6, "R4 same set");
    lr_(16'h0500, 1, "R4 lr"); sc_(16'h0500, 1, 7, "R4 first sc");
    sc_(16'h0540, 1, 8, "R4 other set");
    lr_(16'h0500, 0, "R4 lr"); sc_(16'h0600, 0, 9, "R4 failing sc");
    sc_(16'h0500, 0, 10, "R4 after failing sc");

    // R5 snoops
    lr_(16'h0700, 0, "R5 lr");
    issue(0, 0, 0, 0, 0, 1, 16'h070c, 0, 0, "R5 snoop in set");
    sc_(16'h0700, 0, 11, "R5 sc after snoop");
    lr_(16'h0700, 0, "R5 lr");
    issue(0, 0, 0, 0, 0, 1, 16'h0710, 0, 0, "R5 snoop next set");
    sc_(16'h0700, 0, 12, "R5 sc after far snoop");
    lr_(16'h0700, 0, "R5 lr");
    issue(0, 1, 16'h0704, 0, 13, 1, 16'h0708, 0, 0, "R5 snoop same cycle sc");
    issue(1, 0, 16'h0700, 0, 0, 1, 16'h0700, 0, 0, "R5 snoop same cycle lr");
    sc_(16'h0700, 0, 14, "R5 sc after lr+snoop");

    // R6 local store does not clear with LOCAL_CLEARS=0
    lr_(16'h0800, 1, "R6 lr");
    issue(0, 0, 0, 0, 0, 0, 0, 1, 16'h0808, "R6 local store");
    sc_(16'h0800, 1, 15, "R6 sc after local store");

    // R8 misalignment sweep with a live reservation
    for (int lo = 0; lo < 8; lo++) begin
      lr_(16'h0900, 0, "R8 lr");
      sc_(16'h0900 + 16'(lo), 0, 16, "R8 word sc");
      lr_(16'h0900, 0, "R8 lr");
      sc_(16'h0900 + 16'(lo), 1, 17, "R8 dbl sc");
      lr_(16'h0900, 0, "R8 lr");
      lr_(16'h0a00 + 16'(lo), 1, "R8 dbl lr");
      sc_(16'h0900, 0, 18, "R8 sc after bad lr");
    end

    // R10 reservation persists across idle cycles
    lr_(16'h0b00, 0, "R10 lr");
    for (int i = 0; i < 20; i++)
      issue(0, 0, 0, 0, 0, 0, 0, 1, 16'h0c00 + 16'(i * 4), "R10 idle");
    sc_(16'h0b08, 0, 19, "R10 sc late");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule